// File: doc/BRIEF.md
# Indirect Access Port for a Byte-Banked Word Memory

This block gives a host indirect access to a small internal memory of 128 words of 16 bits. The storage is two independent 8-bit banks: the low byte of every word sits in bank 0 and the high byte in bank 1. Byte number n therefore lives at word n/2, in bank 0 when n is even and in bank 1 when n is odd. A single byte can be written without touching its partner.

The host never addresses the memory directly. It writes a command word that holds an operation code and a word address. It then polls a completion flag in the readable status word. For a read, it collects the result from a separate data register. For writes, it loads the data register first, and the sequencer takes the write data from there. An internal processor owns the memory and has priority over the host. Here it is reduced to one request pin. While that pin is high, a pending host access waits, and it is never dropped.

Every host-side register access is a single-cycle strobe. Nothing in this block streams, so there is no valid/ready pair: the command and data write strobes are plain. The host pacing rule is that it must not start a new command before the completion flag reads 1. A command written earlier is refused and flagged.

Top module: `byte_bank_port`

## Requirements
- R1: After reset, `status_o` and `data_o` both read 0x0000.
- R2: Command word layout: operation code in bits [15:14], word address in bits [7:1], so word address 0x70 with a read is 0x00E0. Bits [13:8] and bit 0 of a command are ignored. `status_o` reads back {op[15:14], 5'b0 [13:9], error [8], address [7:1], done [0]}.
- R3: Operation code 0 reads the addressed 16-bit word into the data register.
- R4: Operation code 1 writes the whole data register to the addressed word, with bits [7:0] going to bank 0 and bits [15:8] going to bank 1.
- R5: Operation code 2 writes only data bits [7:0] into bank 0, and code 3 writes only data bits [15:8] into bank 1. The other byte of the word keeps its value, so byte 2w+1 lives in the high half of word w.
- R6: An accepted command clears done at the clock edge that takes it. With `cpu_req` low, done reads 1 two edges after that edge.
- R7: While a host access is pending, every cycle with `cpu_req` high delays the memory access by one cycle. The access is never lost.
- R8: A command written while an access is in progress leaves the operation, address and memory unchanged. It sets the error bit, which then stays 1 until reset.
- R9: A host write of the data register while an access is in progress is ignored. A write that was already pending uses the data register value from before the ignored write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | One-cycle strobe that writes the command word |
| cmd_wdata | input | 16 | Command word |
| data_we | input | 1 | One-cycle strobe that writes the data register |
| data_wdata | input | 16 | New data register value |
| cpu_req | input | 1 | Internal processor claims the memory this cycle |
| status_o | output | 16 | Command and status readback |
| data_o | output | 16 | Data register |

## Verification
A command taken at edge E0 shows done = 0 from E0 onward. With no contention, the memory is accessed at E1, and the data register and done flag change together at E2. Each stalled cycle pushes both edges back by one. The bench drives its inputs at falling edges. At every falling edge it compares status and data against a behavioural model that is advanced at each rising edge. The directed tests count falling edges after E0 and expect done exactly at 2 plus the number of stall cycles.

// File: rtl/byte_bank_port_pkg.sv
package byte_bank_port_pkg;

  localparam int CMD_W        = 16;
  localparam int CMD_DONE_BIT = 0;
  localparam int CMD_ADDR_LSB = 1;
  localparam int CMD_ERR_BIT  = 8;
  localparam int CMD_OP_LSB   = 14;
  localparam int CMD_OP_W     = 2;

  typedef enum logic [CMD_OP_W-1:0] {
    OP_READ    = 2'd0,
    OP_WR_WORD = 2'd1,
    OP_WR_LO   = 2'd2,
    OP_WR_HI   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PEND = 2'd1,
    SQ_FIN  = 2'd2
  } sq_state_e;

  // Which banks a given operation writes.
  function automatic logic bank_write_sel(op_e op, int bank, int nbank);
    case (op)
      OP_WR_WORD: return 1'b1;
      OP_WR_LO:   return bank == 0;
      OP_WR_HI:   return bank == nbank - 1;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/byte_bank_port_bank.sv
module byte_bank_port_bank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wd;
      rd <= mem[addr];
    end
  end
endmodule

// File: rtl/byte_bank_port_seq.sv
module byte_bank_port_seq
  import byte_bank_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cpu_req,
  output logic issue,
  output logic finish,
  output logic busy
);
  sq_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d   = st_q;
    issue  = 1'b0;
    finish = 1'b0;
    busy   = (st_q != SQ_IDLE);
    case (st_q)
      SQ_IDLE: if (start) st_d = SQ_PEND;
      SQ_PEND: if (!cpu_req) begin
        issue = 1'b1;
        st_d  = SQ_FIN;
      end
      SQ_FIN: begin
        finish = 1'b1;
        st_d   = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // R6: a memory access is always followed by its completion cycle
  assert_issue_then_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> finish);

  // R6: access and completion never share a cycle
  assert_single_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue, finish}));

  // R7: a stalled request stays pending
  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_PEND && cpu_req) |=> (st_q == SQ_PEND));
endmodule

// File: rtl/byte_bank_port.sv
module byte_bank_port
  import byte_bank_port_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8,
  parameter int NBANK  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_we,
  input  logic [CMD_W-1:0]          cmd_wdata,
  input  logic                      data_we,
  input  logic [NBANK*BYTE_W-1:0]   data_wdata,
  input  logic                      cpu_req,
  output logic [CMD_W-1:0]          status_o,
  output logic [NBANK*BYTE_W-1:0]   data_o
);
  localparam int WORD_W = NBANK * BYTE_W;

  logic              busy, issue, finish;
  logic              accept, reject;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, err_q;
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] rd_word;
  logic [NBANK-1:0]  bank_en, bank_we;
  logic              unused_cmd_bits;

  assign accept = cmd_we && !busy;
  assign reject = cmd_we && busy;
  assign unused_cmd_bits = ^{cmd_wdata[CMD_DONE_BIT],
                             cmd_wdata[CMD_OP_LSB-1:CMD_ADDR_LSB+ADDR_W]};

  byte_bank_port_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .cpu_req (cpu_req),
    .issue   (issue),
    .finish  (finish),
    .busy    (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_READ;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (accept) begin
        op_q   <= op_e'(cmd_wdata[CMD_OP_LSB +: CMD_OP_W]);
        addr_q <= cmd_wdata[CMD_ADDR_LSB +: ADDR_W];
        done_q <= 1'b0;
      end
      if (reject) err_q <= 1'b1;
      if (finish) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      data_q <= '0;
    else if (finish && op_q == OP_READ) data_q <= rd_word;
    else if (data_we && !busy)       data_q <= data_wdata;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_en[b] = issue;
    assign bank_we[b] = issue && bank_write_sel(op_q, b, NBANK);

    byte_bank_port_bank #(.AW(ADDR_W), .DW(BYTE_W)) u_bank (
      .clk  (clk),
      .en   (bank_en[b]),
      .we   (bank_we[b]),
      .addr (addr_q),
      .wd   (data_q[b*BYTE_W +: BYTE_W]),
      .rd   (rd_word[b*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    status_o                              = '0;
    status_o[CMD_DONE_BIT]                = done_q;
    status_o[CMD_ADDR_LSB +: ADDR_W]      = addr_q;
    status_o[CMD_ERR_BIT]                 = err_q;
    status_o[CMD_OP_LSB +: CMD_OP_W]      = op_q;
  end

  assign data_o = data_q;

  // R6: taking a command drops done at that edge
  assert_accept_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done_q);

  // R7: the memory is never driven while the processor claims it
  assert_cpu_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_en) |-> !cpu_req);

  // R8: a refused command leaves the latched command alone
  assert_reject_keeps_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ($stable(addr_q) && $stable(op_q) && err_q));

  // R8: the error flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9: the data register is frozen until completion
  assert_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(data_q));
endmodule

// File: tb/test_byte_bank_port.sv
module test_byte_bank_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        data_we = 1'b0;
  logic [15:0] data_wdata = '0;
  logic        cpu_req = 1'b0;
  logic [15:0] status_o, data_o;

  int total = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  byte_bank_port i_byte_bank_port (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .cpu_req(cpu_req),
    .status_o(status_o), .data_o(data_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int          mst = 0;
  logic [15:0] mmem [128];
  logic [15:0] m_data = '0, m_tmp = '0;
  logic [1:0]  m_op = '0;
  logic [6:0]  m_addr = '0;
  logic        m_done = 1'b0, m_err = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; m_done = 0; m_err = 0; m_op = 0; m_addr = 0; m_data = 0;
    end else begin
      case (mst)
        0: begin
          if (data_we) m_data = data_wdata;
          if (cmd_we) begin
            m_op = cmd_wdata[15:14]; m_addr = cmd_wdata[7:1]; m_done = 0; mst = 1;
          end
        end
        1: begin
          if (cmd_we) m_err = 1;
          if (!cpu_req) begin
            case (m_op)
              2'd0: m_tmp = mmem[m_addr];
              2'd1: mmem[m_addr] = m_data;
              2'd2: mmem[m_addr][7:0] = m_data[7:0];
              default: mmem[m_addr][15:8] = m_data[15:8];
            endcase
            mst = 2;
          end
        end
        default: begin
          if (cmd_we) m_err = 1;
          m_done = 1;
          if (m_op == 2'd0) m_data = m_tmp;
          mst = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R6 done", {15'b0, status_o[0]}, {15'b0, m_done});
      chk("R8 error", {15'b0, status_o[8]}, {15'b0, m_err});
      chk("R2 fields", {status_o[15:9], 1'b0, status_o[7:1], 1'b0},
                       {m_op, 5'b0, 1'b0, m_addr, 1'b0});
      chk("R3 data", data_o, m_data);
    end
  end

  function automatic logic [15:0] fv(int w);
    return 16'(w * 257) ^ 16'h5A3C;
  endfunction

  task automatic run_op(input logic [15:0] cmd, input bit wd, input logic [15:0] d,
                        output int lat);
    @(negedge clk);
    cmd_we = 1; cmd_wdata = cmd; data_we = wd; data_wdata = d;
    @(negedge clk);
    cmd_we = 0; data_we = 0; lat = 0;
    while (!status_o[0] && lat < 50) begin @(negedge clk); lat++; end
  endtask

  function automatic logic [15:0] mk(input logic [1:0] op, input int a);
    return {op, 6'b0, 7'(a), 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 status", status_o, 16'h0000);
    chk("R1 data", data_o, 16'h0000);
    rst_n = 1;
    cmp_on = 1;

    for (int w = 0; w < 128; w++) run_op(mk(2'd1, w), 1, fv(w), lat);

    // R3 / R6: plain read of word 0x70 with command 0x00E0
    run_op(16'h00E0, 0, 16'h0, lat);
    chk("R6 latency", 16'(lat), 16'd2);
    chk("R3 read 0x70", data_o, fv(8'h70));

    // R2: junk in bits [13:8] and bit 0 is ignored
    run_op(16'h3FE1, 0, 16'h0, lat);
    chk("R2 status readback", status_o, 16'h00E1);
    chk("R2 read data", data_o, fv(8'h70));

    // R4: whole-word write then read back
    run_op(mk(2'd1, 8'h7F), 1, 16'hC0DE, lat);
    chk("R6 write latency", 16'(lat), 16'd2);
    run_op(mk(2'd0, 8'h7F), 0, 16'h0, lat);
    chk("R4 word write", data_o, 16'hC0DE);

    // R5: low byte of word 5, high byte of word 6 (byte 13)
    run_op(mk(2'd2, 5), 1, 16'hBEEF, lat);
    run_op(mk(2'd0, 5), 0, 16'h0, lat);
    chk("R5 low byte", data_o, {fv(5)[15:8], 8'hEF});
    run_op(mk(2'd3, 6), 1, 16'h1234, lat);
    run_op(mk(2'd0, 6), 0, 16'h0, lat);
    chk("R5 high byte", data_o, {8'h12, fv(6)[7:0]});

    // R7 / R9: stalled write, data write during the stall is ignored
    @(negedge clk);
    cmd_we = 1; cmd_wdata = mk(2'd1, 8'h21); data_we = 1; data_wdata = 16'h4444; cpu_req = 1;
    @(negedge clk);
    cmd_we = 0; data_we = 1; data_wdata = 16'hFFFF; lat = 0;
    @(negedge clk);
    data_we = 0; lat = 1;
    chk("R9 data held", data_o, 16'h4444);
    @(negedge clk);
    cpu_req = 0; lat = 2;
    chk("R7 still pending", {15'b0, status_o[0]}, 16'h0);
    while (!status_o[0] && lat < 50) begin @(negedge clk); lat++; end
    chk("R7 stalled latency", 16'(lat), 16'd4);
    run_op(mk(2'd0, 8'h21), 0, 16'h0, lat);
    chk("R9 stored value", data_o, 16'h4444);

    // R8: command during an access is refused and flagged
    @(negedge clk);
    cmd_we = 1; cmd_wdata = mk(2'd0, 8'h10);
    @(negedge clk);
    cmd_wdata = mk(2'd1, 1);
    @(negedge clk);
    cmd_we = 0;
    chk("R8 error set", {15'b0, status_o[8]}, 16'h1);
    chk("R8 address kept", {9'b0, status_o[7:1]}, 16'h10);
    lat = 0;
    while (!status_o[0] && lat < 50) begin @(negedge clk); lat++; end
    chk("R8 read kept", data_o, fv(8'h10));
    run_op(mk(2'd0, 1), 0, 16'h0, lat);
    chk("R8 memory kept", data_o, fv(1));
    chk("R8 error sticky", {15'b0, status_o[8]}, 16'h1);

    // Mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cpu_req    = ($urandom % 3) == 0;
      cmd_we     = ($urandom % 4) == 0;
      cmd_wdata  = 16'($urandom);
      data_we    = ($urandom % 3) == 0;
      data_wdata = 16'($urandom);
    end
    @(negedge clk);
    cmd_we = 0; data_we = 0; cpu_req = 0;
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule